// File: doc/BRIEF.md
# Video Line Gain Regulator

This block closes a digital automatic gain control loop around a video ADC. Each line, the digitized samples stream in. Two strobes mark the samples of the sync-tip window and the back-porch window. The block averages each window. It measures the code distance from sync tip to back porch and compares that distance with one of two programmable targets. It then moves a gain word toward the value that makes the distance match the target. The gain word drives an external analog gain stage. A larger word means more gain, and 0 is the lowest gain.

The loop integrates the error in a fractional accumulator. A two-bit time-constant field and an acquisition speed-up set how large each step is. If the ADC reaches full scale during a line, an optional overflow guard forces one step of gain reduction on that line. A freeze control holds the loop state and puts a host-supplied manual gain on the output. A lock flag reports that the loop has settled.

The sample input is a valid/ready stream. `in_ready` is always high, so the block never applies back-pressure. A sample transfers in every cycle where `in_valid` is high. The last line is closed by a one-cycle `line_done` pulse in a cycle after the last sample. A sample presented in the same cycle as `line_done` counts toward the next line. All configuration inputs are plain levels and are sampled at `line_done`. The one exception is `cfg_freeze`, which switches the output at once.

Top module: `video_agc`

## Requirements
- R1: `in_ready` is high at all times, including during reset. A cycle with `in_valid` low has no effect, whatever the data and strobe values in that cycle.
- R2: Each window average is the floor of the mean of the first 4 valid samples that carry that window's strobe in the line. Later samples in the window are ignored. If either window has fewer than 4 samples, the line makes no error update and no lock update.
- R3: The measured distance is porch average minus tip average. The target is 68 when `cfg_gain_sel` is 0 and 54 when it is 1. The error is the target minus the measured distance.
- R4: The loop state is an accumulator with 8 integer bits and 5 fraction bits. On a measured line it adds error × 2^(5−s), where s = 2 + `cfg_tc`. `gain_out` is the integer part, and it shows the update in the cycle after `line_done`.
- R5: The accumulator saturates: it never goes below 0 and never goes above 255 plus all fraction bits. It does not wrap.
- R6: When `cfg_acq_en` is 1 and `locked` is 0, s is reduced by one, which doubles the step.
- R7: If `cfg_ovf_en` is 1 and any valid sample in the line equals 255, the accumulator drops by exactly 1.0 (floored at 0). The error update is skipped and the lock counters are left unchanged.
- R8: When `cfg_ovf_en` is 0, a full-scale sample gets no special treatment and the normal error update happens.
- R9: While `cfg_freeze` is 1, `gain_out` equals `cfg_manual` from the same cycle and the accumulator does not change. After release, the output returns to the held accumulator value.
- R10: `locked` becomes 1 at the end of the 8th consecutive measured line with |error| ≤ 2.
- R11: `locked` becomes 0 at the end of the 4th consecutive measured line with |error| > 6.
- R12: Reset sets the gain to 128 and clears the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample valid |
| in_ready | output | 1 | Sample ready, always 1 |
| in_data | input | 8 | ADC sample code |
| in_tip | input | 1 | Sample belongs to the sync-tip window |
| in_porch | input | 1 | Sample belongs to the back-porch window |
| line_done | input | 1 | One-cycle pulse that closes the line |
| cfg_gain_sel | input | 1 | Target select: 0 gives 68, 1 gives 54 |
| cfg_ovf_en | input | 1 | Enable forced reduction on full-scale samples |
| cfg_freeze | input | 1 | Hold the loop and output the manual gain |
| cfg_manual | input | 8 | Manual gain used while frozen |
| cfg_tc | input | 2 | Tracking time-constant select |
| cfg_acq_en | input | 1 | Double the step size while unlocked |
| gain_out | output | 8 | Gain word to the analog stage |
| locked | output | 1 | Loop settled flag |

## Verification
On a single line, the overflow guard and the tip-to-porch error update can both be triggered: both windows hold enough samples and an active-video sample sits at 255. The bench builds such lines with a large, nonzero error. It expects only the 1.0 decrement and no change to the lock run, even while a good/bad run is partly counted. Freeze and overflow also meet on one line, and there the held accumulator must win. A masked 255 carried with `in_valid` low on the tip strobe confirms that neither the guard nor the window average sees it.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef logic [7:0] code_t;
  typedef logic signed [9:0] err_t;

  function automatic logic [9:0] mag(input err_t e);
    return e[9] ? 10'(-e) : 10'(e);
  endfunction
endpackage

// File: rtl/agc_window.sv
module agc_window #(
  parameter int WIN_LG = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_en,
  input  logic        line_done,
  input  agc_pkg::code_t smp,
  output agc_pkg::code_t avg,
  output logic        full
);
  localparam int WIN = 1 << WIN_LG;
  localparam int CW  = WIN_LG + 1;
  localparam int SW  = 8 + WIN_LG;

  logic [CW-1:0] cnt;
  logic [SW-1:0] sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sum <= '0;
    end else if (line_done) begin
      cnt <= smp_en ? CW'(1) : '0;
      sum <= smp_en ? SW'(smp) : '0;
    end else if (smp_en && cnt != CW'(WIN)) begin
      cnt <= cnt + CW'(1);
      sum <= sum + SW'(smp);
    end
  end

  assign avg  = sum[SW-1:WIN_LG];
  assign full = (cnt == CW'(WIN));

  // R2
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(WIN));
  // R2
  sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && !line_done |=> $stable(sum));
endmodule

// File: rtl/agc_lock.sv
module agc_lock #(
  parameter int LOCK_LINES = 8,
  parameter int LOSS_LINES = 4,
  parameter int LOCK_TOL   = 2,
  parameter int LOSS_TOL   = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd,
  input  logic [9:0] err_mag,
  output logic       locked
);
  localparam int GW = $clog2(LOCK_LINES + 1);
  localparam int BW = $clog2(LOSS_LINES + 1);

  logic [GW-1:0] good_run;
  logic [BW-1:0] bad_run;
  logic good, bad;

  assign good = (err_mag <= 10'(LOCK_TOL));
  assign bad  = (err_mag >  10'(LOSS_TOL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_run <= '0;
      bad_run  <= '0;
      locked   <= 1'b0;
    end else if (upd) begin
      if (good) begin
        bad_run <= '0;
        if (good_run == GW'(LOCK_LINES - 1)) locked <= 1'b1;
        else good_run <= good_run + GW'(1);
      end else if (bad) begin
        good_run <= '0;
        if (bad_run == BW'(LOSS_LINES - 1)) locked <= 1'b0;
        else bad_run <= bad_run + BW'(1);
      end else begin
        good_run <= '0;
        bad_run  <= '0;
      end
    end
  end

  // R10
  lock_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !upd |=> $stable(locked));
  // R11
  lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked && upd && good |=> locked);
endmodule

// File: rtl/agc_integ.sv
module agc_integ #(
  parameter int INIT_GAIN  = 128,
  parameter int SHIFT_BASE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_err,
  input  logic          dec,
  input  agc_pkg::err_t err,
  input  logic [2:0]    shift,
  output agc_pkg::code_t gain
);
  localparam int FRAC = SHIFT_BASE + 3;
  localparam int AW   = 8 + FRAC;
  localparam int XW   = AW + 6;

  logic [AW-1:0] acc;
  logic [2:0] shamt;
  logic signed [XW-1:0] step, nxt;
  logic [AW-1:0] sat;

  assign shamt = 3'(FRAC) - shift;
  assign step  = $signed({{(XW-10){err[9]}}, err}) <<< shamt;
  assign nxt   = $signed({6'b0, acc}) + step;

  always_comb begin
    if (nxt[XW-1])            sat = '0;
    else if (|nxt[XW-2:AW])   sat = '1;
    else                      sat = nxt[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc <= AW'(INIT_GAIN) << FRAC;
    else if (dec)     acc <= (acc >= (AW'(1) << FRAC)) ? acc - (AW'(1) << FRAC) : '0;
    else if (upd_err) acc <= sat;
  end

  assign gain = acc[AW-1:FRAC];

  // R9
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_err || dec) |=> $stable(acc));
  // R7
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec && gain != 8'd0 |=> gain == $past(gain) - 8'd1);
endmodule

// File: rtl/video_agc.sv
module video_agc #(
  parameter int WIN_LG     = 2,
  parameter int INIT_GAIN  = 128,
  parameter int SHIFT_BASE = 2,
  parameter int LOCK_LINES = 8,
  parameter int LOSS_LINES = 4,
  parameter int LOCK_TOL   = 2,
  parameter int LOSS_TOL   = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_tip,
  input  logic       in_porch,
  input  logic       line_done,
  input  logic       cfg_gain_sel,
  input  logic       cfg_ovf_en,
  input  logic       cfg_freeze,
  input  logic [7:0] cfg_manual,
  input  logic [1:0] cfg_tc,
  input  logic       cfg_acq_en,
  output logic [7:0] gain_out,
  output logic       locked
);
  import agc_pkg::*;

  localparam int TGT_LO = 68;
  localparam int TGT_HI = 54;

  code_t tip_avg, porch_avg, loop_gain;
  logic  tip_full, porch_full, hit_max, max_now;
  logic  meas_ok, ovf_line, upd_err, dec, lock_upd, acq_fast;
  err_t  diff, err;
  logic [2:0] shift;

  assign in_ready = 1'b1;
  assign max_now  = in_valid && in_data == 8'hFF;

  agc_window #(.WIN_LG(WIN_LG)) u_tip (
    .clk(clk), .rst_n(rst_n), .smp_en(in_valid && in_tip), .line_done(line_done),
    .smp(in_data), .avg(tip_avg), .full(tip_full));

  agc_window #(.WIN_LG(WIN_LG)) u_porch (
    .clk(clk), .rst_n(rst_n), .smp_en(in_valid && in_porch), .line_done(line_done),
    .smp(in_data), .avg(porch_avg), .full(porch_full));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hit_max <= 1'b0;
    else if (line_done) hit_max <= max_now;
    else if (max_now)   hit_max <= 1'b1;
  end

  assign diff     = $signed({2'b0, porch_avg}) - $signed({2'b0, tip_avg});
  assign err      = (cfg_gain_sel ? 10'sd54 : 10'sd68) - diff;
  assign meas_ok  = tip_full && porch_full;
  assign ovf_line = cfg_ovf_en && hit_max;
  assign upd_err  = line_done && meas_ok && !ovf_line && !cfg_freeze;
  assign dec      = line_done && ovf_line && !cfg_freeze;
  assign lock_upd = line_done && meas_ok && !ovf_line;
  assign acq_fast = cfg_acq_en && !locked;
  assign shift    = 3'(SHIFT_BASE) + {1'b0, cfg_tc} - {2'b0, acq_fast};

  agc_integ #(.INIT_GAIN(INIT_GAIN), .SHIFT_BASE(SHIFT_BASE)) u_integ (
    .clk(clk), .rst_n(rst_n), .upd_err(upd_err), .dec(dec), .err(err),
    .shift(shift), .gain(loop_gain));

  agc_lock #(.LOCK_LINES(LOCK_LINES), .LOSS_LINES(LOSS_LINES),
             .LOCK_TOL(LOCK_TOL), .LOSS_TOL(LOSS_TOL)) u_lock (
    .clk(clk), .rst_n(rst_n), .upd(lock_upd), .err_mag(mag(err)), .locked(locked));

  assign gain_out = cfg_freeze ? cfg_manual : loop_gain;

  // R1
  max_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && !line_done |=> $stable(hit_max));
  // R7
  ovf_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_done && ovf_line |=> $stable(locked));
endmodule

// File: tb/video_agc_test.sv
module video_agc_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_tip = 0, in_porch = 0, line_done = 0;
  logic [7:0] in_data = 0;
  logic cfg_gain_sel = 0, cfg_ovf_en = 0, cfg_freeze = 0, cfg_acq_en = 0;
  logic [7:0] cfg_manual = 0;
  logic [1:0] cfg_tc = 0;
  logic in_ready, locked;
  logic [7:0] gain_out;

  int n_chk = 0, n_bad = 0;
  int m_acc = 128 * 32;
  bit m_lock = 0;
  int m_good = 0, m_bad = 0;
  int q_gain[$];
  bit q_lock[$];
  string q_tag[$];
  bit pend = 0;

  always #10 clk = ~clk;

  video_agc uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_tip(in_tip), .in_porch(in_porch), .line_done(line_done),
    .cfg_gain_sel(cfg_gain_sel), .cfg_ovf_en(cfg_ovf_en), .cfg_freeze(cfg_freeze),
    .cfg_manual(cfg_manual), .cfg_tc(cfg_tc), .cfg_acq_en(cfg_acq_en),
    .gain_out(gain_out), .locked(locked));

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put(input bit v, input int d, input bit t, input bit p);
    @(posedge clk); #2;
    in_valid = v; in_data = 8'(d); in_tip = t; in_porch = p;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (pend) begin
      check(gain_out, q_gain.pop_front(), {q_tag[0], " gain"});
      check(locked, q_lock.pop_front(), {q_tag.pop_front(), " lock"});
    end
    pend = line_done;
  end

  task automatic model(input int tv, input int nt, input int pv, input int np, input bit mx);
    bit meas, ovf;
    int err, sh;
    meas = nt >= 4 && np >= 4;
    ovf = cfg_ovf_en && mx;
    err = (cfg_gain_sel ? 54 : 68) - (pv - tv);
    if (!cfg_freeze) begin
      if (ovf) m_acc = (m_acc >= 32) ? m_acc - 32 : 0;
      else if (meas) begin
        sh = 2 + cfg_tc - ((cfg_acq_en && !m_lock) ? 1 : 0);
        m_acc = m_acc + err * (1 << (5 - sh));
        if (m_acc < 0) m_acc = 0;
        if (m_acc > 255 * 32 + 31) m_acc = 255 * 32 + 31;
      end
    end
    if (meas && !ovf) begin
      if (err <= 2 && err >= -2) begin
        m_bad = 0; m_good++;
        if (m_good >= 8) m_lock = 1;
      end else if (err > 6 || err < -6) begin
        m_good = 0; m_bad++;
        if (m_bad >= 4) m_lock = 0;
      end else begin
        m_good = 0; m_bad = 0;
      end
    end
  endtask

  task automatic run_line(input int tv, input int nt, input int pv, input int np,
                          input bit mx, input string tag);
    put(1, 100, 0, 0);
    put(1, 101, 0, 0);
    if (mx) put(1, 255, 0, 0);
    put(0, 255, 1, 0);          // masked sample: R1
    for (int i = 0; i < nt; i++) put(1, tv, 1, 0);
    put(1, 40, 0, 0);
    for (int i = 0; i < np; i++) put(1, pv, 0, 1);
    if (np >= 4) begin
      put(1, 200, 0, 1);        // beyond the window: R2
      put(1, 200, 0, 1);
    end
    @(posedge clk); #2;
    in_valid = 0; in_tip = 0; in_porch = 0; line_done = 1;
    model(tv, nt, pv, np, mx);
    q_gain.push_back(cfg_freeze ? int'(cfg_manual) : m_acc / 32);
    q_lock.push_back(m_lock);
    q_tag.push_back(tag);
    @(posedge clk); #2;
    line_done = 0;
    @(posedge clk);
    @(posedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    check(gain_out, 128, "R12 reset gain");
    check(locked, 0, "R12 reset lock");
    check(in_ready, 1, "R1 ready");
    cfg_ovf_en = 1;
    // R3 R10: on-target lines until lock
    for (int i = 0; i < 8; i++) run_line(2, 4, 70, 4, 0, "R10 lock in");
    // R4: err 8 at tc 0 then tc 3
    run_line(10, 4, 70, 4, 0, "R4 tc0");
    cfg_tc = 3;
    run_line(10, 4, 70, 4, 0, "R4 tc3");
    cfg_gain_sel = 1;
    run_line(16, 5, 70, 6, 0, "R3 sel1");
    // R11: err 14 for 4 lines
    for (int i = 0; i < 4; i++) run_line(30, 4, 70, 4, 0, "R11 lock loss");
    cfg_acq_en = 1;
    run_line(30, 4, 70, 4, 0, "R6 acquire");
    // R7: overflow beats error
    run_line(30, 4, 70, 4, 1, "R7 overflow");
    cfg_ovf_en = 0;
    run_line(30, 4, 70, 4, 1, "R8 ovf off");
    cfg_ovf_en = 1;
    // R2: short tip window
    run_line(30, 3, 70, 4, 0, "R2 short");
    run_line(30, 4, 70, 2, 0, "R2 short porch");
    // R9: freeze
    cfg_manual = 77; cfg_freeze = 1;
    @(negedge clk);
    check(gain_out, 77, "R9 freeze out");
    run_line(0, 4, 250, 4, 0, "R9 frozen err");
    run_line(30, 4, 70, 4, 1, "R9 frozen ovf");
    cfg_freeze = 0;
    @(negedge clk);
    check(gain_out, m_acc / 32, "R9 release");
    // R5: saturate high then low
    cfg_gain_sel = 0; cfg_tc = 0; cfg_acq_en = 0;
    for (int i = 0; i < 12; i++) run_line(2, 4, 10, 4, 0, "R5 high");
    for (int i = 0; i < 8; i++) run_line(0, 4, 250, 4, 0, "R5 low");
    run_line(30, 4, 70, 4, 1, "R7 floor");
    @(negedge clk);
    check(gain_out, 0, "R5 floor gain");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule